// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-facing front end of a serial memory that answers on a two-wire (I2C-style) bus. It runs on a fast system clock and treats the bus clock and data lines as slow inputs. Both lines pass through synchronizers, and every bus event is found from edges of the synchronized samples. The block recognizes START and STOP, and takes in a control byte made of a fixed 4-bit device type and three select bits. It answers only when the type is `1010` and the select bits equal its strap pins. It then loads a 13-bit word address sent as two bytes.

In write mode, each following data byte goes to a write cache as a one-cycle pulse carrying an address and a byte. The pointer then advances inside a 64-byte window. In read mode, bytes are fetched from a combinational memory port at the current pointer and shifted out MSB first. The pointer then advances over the whole address space. A random read is a write-mode control byte and an address, then a repeated START and a read-mode control byte.

The data line is open-drain. The block only pulls it low or releases it, and it changes that state only a set number of system cycles after a falling bus-clock edge. While the memory reports a programming cycle in progress, the block acknowledges nothing.

Top module: `tw_mem_slave`

## Requirements
- R1: A STOP (data rising while the clock is high) returns the slave to idle from any point, including the middle of a byte. Bytes clocked afterwards without a new START get no acknowledge.
- R2: The control byte is, MSB first, the type code in bits 7..4, the select bits in bits 3..1 and the direction in bit 0 (1 = read). The slave acknowledges it only if bits 7..4 are `1010` and bits 3..1 equal `strap_i`. Otherwise it never pulls SDA low.
- R3: The slave acknowledges a byte by pulling SDA low during the whole high phase of that byte's ninth clock.
- R4: While `busy_i` is high at the end of a byte, that byte is not acknowledged and no write pulse is issued. The slave then ignores the bus until the next START.
- R5: The word address arrives as a high byte and then a low byte. The three top bits of the high byte are ignored, and the pointer takes bits 4..0 of the high byte as A12..A8.
- R6: Each acknowledged write data byte gives exactly one one-cycle `wr_valid_o` pulse, with the current pointer and the byte. Then the low 6 pointer bits increment and wrap, and bits 12..6 stay the same.
- R7: In read mode the slave sends `rd_data_i`, read at the current pointer, MSB first. After each byte the full 13-bit pointer increments, wrapping from 0x1FFF to 0x0000.
- R8: If the master leaves SDA high in the acknowledge slot of a read byte, the slave releases SDA and drives nothing until the next START.
- R9: The slave changes SDA from released to pulled low only while SCL is low. It does so `HOLD_CYC` system cycles after it detects the SCL falling edge, never at once.
- R10: A START at any point, including a repeated START in the middle of a byte, drops the partial byte and begins a fresh control-byte reception.
- R11: After reset, SDA is released and `wr_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_drive_low_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 3 | Device select straps compared with control bits 3..1 |
| busy_i | input | 1 | High while a programming cycle is in progress |
| rd_addr_o | output | ADDR_W | Current pointer, used as the read address |
| rd_data_i | input | 8 | Memory byte at `rd_addr_o`, combinational |
| wr_valid_o | output | 1 | One-cycle pulse per accepted write byte |
| wr_addr_o | output | ADDR_W | Address of the write byte |
| wr_data_o | output | 8 | Write byte |

## Verification
The assertions assume that the master moves SDA only while SCL is low, except to make START and STOP. They also assume that each SCL phase lasts well beyond the synchronizer depth plus `HOLD_CYC`, so that one bus edge never overlaps the pending output delay of the previous one. They further assume that `busy_i` changes only between bytes.

The bench master holds each bus phase for 20 system cycles and changes SDA two cycles after it lowers SCL. It changes `busy_i` only at byte boundaries, so every stimulus stays inside those limits.

// File: rtl/tw_pkg.sv
package tw_pkg;

    // Protocol phase of the slave
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CTRL = 3'd1,
        ST_AHI  = 3'd2,
        ST_ALO  = 3'd3,
        ST_WDAT = 3'd4,
        ST_RDAT = 3'd5
    } tw_state_e;

    // Device type code expected in control bits 7..4
    localparam logic [3:0] TW_TYPE_CODE = 4'b1010;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int   WIDTH     = 2,
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= {WIDTH{RESET_VAL}};
                else        stg_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= {WIDTH{RESET_VAL}};
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/tw_cond_det.sv
module tw_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s_i;
            sda_p_q <= sda_s_i;
        end
    end

    // data edges are conditions only while the clock stays high
    assign start_o = scl_s_i & scl_p_q &  sda_p_q & ~sda_s_i;
    assign stop_o  = scl_s_i & scl_p_q & ~sda_p_q &  sda_s_i;
    assign rise_o  =  scl_s_i & ~scl_p_q;
    assign fall_o  = ~scl_s_i &  scl_p_q;

endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
    import tw_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_BITS   = 6,
    parameter int HOLD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_low_o,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o
);

    localparam int HI_BITS = ADDR_W - 8;
    localparam int DLY_W   = $clog2(HOLD_CYC + 1);
    localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(HOLD_CYC);
    localparam logic [DLY_W-1:0] DLY_ONE  = DLY_W'(1);

    typedef struct packed {
        tw_state_e         st;
        logic [3:0]        bcnt;   // clock rises seen in this byte slot
        logic [7:0]        sh;
        logic [ADDR_W-1:0] ptr;
        logic              rd;
        logic              ack;
        logic              tgt;    // pending drive-low value
        logic              drv;
        logic [DLY_W-1:0]  dly;
        logic              wv;
        logic [ADDR_W-1:0] wa;
        logic [7:0]        wd;
    } regs_t;

    regs_t d, q;

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       start_ev, stop_ev, rise_ev, fall_ev;
    logic [7:0] byte_in;

    tw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    tw_cond_det cond_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s_i (scl_s),
        .sda_s_i (sda_s),
        .start_o (start_ev),
        .stop_o  (stop_ev),
        .rise_o  (rise_ev),
        .fall_o  (fall_ev)
    );

    assign byte_in = {q.sh[6:0], sda_s};

    always_comb begin
        d    = q;
        d.wv = 1'b0;

        // output delay after a clock fall
        if (q.dly != '0) begin
            d.dly = q.dly - DLY_ONE;
            if (q.dly == DLY_ONE) d.drv = q.tgt;
        end

        if (stop_ev) begin
            d.st   = ST_IDLE;
            d.bcnt = 4'd0;
            d.tgt  = 1'b0;
            d.drv  = 1'b0;
            d.dly  = '0;
        end else if (start_ev) begin
            d.st   = ST_CTRL;
            d.bcnt = 4'd0;
            d.tgt  = 1'b0;
            d.drv  = 1'b0;
            d.dly  = '0;
        end else if (q.st != ST_IDLE) begin
            if (rise_ev) begin
                if (q.bcnt < 4'd8) begin
                    d.bcnt = q.bcnt + 4'd1;
                    if (q.st != ST_RDAT) begin
                        d.sh = byte_in;
                        if (q.bcnt == 4'd7) begin
                            d.ack = ~busy_i;
                            case (q.st)
                                ST_CTRL: begin
                                    d.ack = ~busy_i && (byte_in[7:4] == TW_TYPE_CODE)
                                            && (byte_in[3:1] == strap_i);
                                    d.rd  = byte_in[0];
                                end
                                ST_AHI: if (!busy_i) d.ptr[ADDR_W-1:8] = byte_in[HI_BITS-1:0];
                                ST_ALO: if (!busy_i) d.ptr[7:0] = byte_in;
                                ST_WDAT: if (!busy_i) begin
                                    d.wv = 1'b1;
                                    d.wa = q.ptr;
                                    d.wd = byte_in;
                                    d.ptr[PAGE_BITS-1:0] = q.ptr[PAGE_BITS-1:0] + PAGE_BITS'(1);
                                end
                                default: ;
                            endcase
                        end
                    end
                end else if (q.bcnt == 4'd8) begin
                    d.bcnt = 4'd9;
                    if (q.st == ST_RDAT) d.ack = ~sda_s;   // master acknowledge
                end
            end else if (fall_ev) begin
                d.dly = DLY_LOAD;
                if (q.st == ST_RDAT) begin
                    if (q.bcnt >= 4'd1 && q.bcnt <= 4'd7) begin
                        d.sh  = {q.sh[6:0], 1'b0};
                        d.tgt = ~q.sh[6];
                    end else if (q.bcnt == 4'd8) begin
                        d.tgt = 1'b0;
                        d.ptr = q.ptr + ADDR_W'(1);
                    end else if (q.bcnt == 4'd9) begin
                        if (q.ack) begin
                            d.sh   = rd_data_i;
                            d.tgt  = ~rd_data_i[7];
                            d.bcnt = 4'd0;
                        end else begin
                            d.st  = ST_IDLE;
                            d.tgt = 1'b0;
                        end
                    end
                end else begin
                    if (q.bcnt == 4'd8) begin
                        d.tgt = q.ack;
                    end else if (q.bcnt == 4'd9) begin
                        d.tgt  = 1'b0;
                        d.bcnt = 4'd0;
                        if (!q.ack) begin
                            d.st = ST_IDLE;
                        end else begin
                            case (q.st)
                                ST_CTRL: begin
                                    if (q.rd) begin
                                        d.st  = ST_RDAT;
                                        d.sh  = rd_data_i;
                                        d.tgt = ~rd_data_i[7];
                                    end else begin
                                        d.st = ST_AHI;
                                    end
                                end
                                ST_AHI:  d.st = ST_ALO;
                                ST_ALO:  d.st = ST_WDAT;
                                default: d.st = q.st;
                            endcase
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, bcnt: 4'd0, sh: 8'd0, ptr: '0, rd: 1'b0, ack: 1'b0,
                   tgt: 1'b0, drv: 1'b0, dly: '0, wv: 1'b0, wa: '0, wd: 8'd0};
        end else begin
            q <= d;
        end
    end

    assign sda_drive_low_o = q.drv;
    assign rd_addr_o       = q.ptr;
    assign wr_valid_o      = q.wv;
    assign wr_addr_o       = q.wa;
    assign wr_data_o       = q.wd;

    // R9: pulling the line low starts only while the clock is low
    a_r9_low_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low_o) |-> !scl_s);

    // R6: a write pulse lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);

    // R4: no write issued from a byte ending while busy
    a_r4_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> !$past(busy_i));

    // R1: a STOP leaves the slave idle
    a_r1_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (q.st == ST_IDLE));

    // R8: idle with nothing pending means the line is released
    a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && q.dly == '0) |-> !sda_drive_low_o);

endmodule

// File: tb/tw_mem_slave_tb.sv
module tw_mem_slave_tb_top;

    localparam int HALF = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        m_scl, m_sda;
    logic        sda_bus;
    logic        drv;
    logic [2:0]  strap;
    logic        busy;
    logic [12:0] rd_addr;
    logic [7:0]  rd_data;
    logic        wv;
    logic [12:0] wa;
    logic [7:0]  wd;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct { logic [12:0] a; logic [7:0] d; } wr_t;
    wr_t exp_q[$];

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b110};
    endfunction

    assign sda_bus = m_sda & ~drv;
    assign rd_data = mem_f(rd_addr);

    tw_mem_slave dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (m_scl),
        .sda_i           (sda_bus),
        .sda_drive_low_o (drv),
        .strap_i         (strap),
        .busy_i          (busy),
        .rd_addr_o       (rd_addr),
        .rd_data_i       (rd_data),
        .wr_valid_o      (wv),
        .wr_addr_o       (wa),
        .wr_data_o       (wd)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the scoreboard on every write pulse
    always @(negedge clk) begin
        if (rst_n && wv) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R6 unexpected write actual=%0h expected=none", {wa, wd});
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                check_eq("R6 write address", 32'(wa), 32'(e.a));
                check_eq("R6 write data", 32'(wd), 32'(e.d));
            end
        end
    end

    task automatic bus_start();
        m_sda = 1'b1; tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_sda = 1'b1; tick(HALF);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_scl = 1'b0; tick(2);
    endtask

    // sends a byte, returns whether the slave held SDA low through the ninth high phase
    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s1, s2, s3;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1;
        tick(1);
        check_eq("R9 no drive right after SCL fall", 32'(drv), 32'd0);
        tick(HALF - 1);
        m_scl = 1'b1;
        tick(1);  s1 = ~sda_bus;
        tick(HALF/2); s2 = ~sda_bus;
        tick(HALF/2 - 2); s3 = ~sda_bus;
        tick(1);
        m_scl = 1'b0;
        tick(2);
        acked = s1 & s2 & s3;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; tick(HALF);
            m_scl = 1'b1; tick(HALF/2);
            v[i] = sda_bus; tick(HALF/2);
            m_scl = 1'b0; tick(2);
        end
        m_sda = ~mack; tick(HALF);
        m_scl = 1'b1;  tick(HALF);
        m_scl = 1'b0;  tick(2);
        m_sda = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic       ak;
        logic [7:0] v;
        logic       any_drv;
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; strap = 3'b101; busy = 1'b0;
        tick(5);
        // R11: reset state
        check_eq("R11 SDA released in reset", 32'(drv), 32'd0);
        check_eq("R11 write pulse low in reset", 32'(wv), 32'd0);
        rst_n = 1'b1;
        tick(10);

        // R2: wrong type code and wrong select bits
        bus_start(); send_byte(8'hBA, ak); check_eq("R2 wrong type no ack", 32'(ak), 32'd0); bus_stop();
        bus_start(); send_byte(8'hA6, ak); check_eq("R2 wrong strap no ack", 32'(ak), 32'd0); bus_stop();

        // R2 R3 R5: byte write with nonzero top address bits
        exp_q.push_back('{a: 13'h034C, d: 8'h5A});
        bus_start();
        send_byte(8'hAA, ak); check_eq("R2 R3 control ack", 32'(ak), 32'd1);
        send_byte(8'hE3, ak); check_eq("R5 high address ack", 32'(ak), 32'd1);
        send_byte(8'h4C, ak); check_eq("R5 low address ack", 32'(ak), 32'd1);
        send_byte(8'h5A, ak); check_eq("R3 data ack", 32'(ak), 32'd1);
        bus_stop();

        // R6: page write wrapping in the low six bits
        exp_q.push_back('{a: 13'h013E, d: 8'h11});
        exp_q.push_back('{a: 13'h013F, d: 8'h22});
        exp_q.push_back('{a: 13'h0100, d: 8'h33});
        exp_q.push_back('{a: 13'h0101, d: 8'h44});
        bus_start();
        send_byte(8'hAA, ak); send_byte(8'h01, ak); send_byte(8'h3E, ak);
        send_byte(8'h11, ak); send_byte(8'h22, ak); send_byte(8'h33, ak); send_byte(8'h44, ak);
        check_eq("R6 last page byte ack", 32'(ak), 32'd1);
        bus_stop();

        // R4: busy blocks the control byte, then a data byte
        busy = 1'b1;
        bus_start(); send_byte(8'hAA, ak); check_eq("R4 control no ack while busy", 32'(ak), 32'd0); bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(8'hAA, ak); send_byte(8'h00, ak); send_byte(8'h10, ak);
        busy = 1'b1;
        send_byte(8'h77, ak); check_eq("R4 data no ack while busy", 32'(ak), 32'd0);
        send_byte(8'h78, ak); check_eq("R4 ignored after refused byte", 32'(ak), 32'd0);
        bus_stop();
        busy = 1'b0;

        // R7 R10: random read across the top of the address space
        bus_start();
        send_byte(8'hAA, ak); send_byte(8'h1F, ak); send_byte(8'hFE, ak);
        bus_start();
        send_byte(8'hAB, ak); check_eq("R10 read control after repeated START", 32'(ak), 32'd1);
        recv_byte(1'b1, v); check_eq("R7 read byte 0x1FFE", 32'(v), 32'(mem_f(13'h1FFE)));
        recv_byte(1'b1, v); check_eq("R7 read byte 0x1FFF", 32'(v), 32'(mem_f(13'h1FFF)));
        recv_byte(1'b0, v); check_eq("R7 read wraps to 0x0000", 32'(v), 32'(mem_f(13'h0000)));
        // R8: released after master NACK
        any_drv = 1'b0;
        for (int i = 0; i < 40; i++) begin tick(1); any_drv |= drv; end
        check_eq("R8 released after NACK", 32'(any_drv), 32'd0);
        bus_stop();

        // R10: repeated START in mid byte
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte(8'hAB, ak); check_eq("R10 control after mid-byte START", 32'(ak), 32'd1);
        recv_byte(1'b0, v); check_eq("R7 pointer kept after NACKed byte", 32'(v), 32'(mem_f(13'h0001)));
        bus_stop();

        // R1: STOP in mid byte, then a byte without START
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        send_byte(8'hAA, ak); check_eq("R1 no ack without START", 32'(ak), 32'd0);
        bus_stop();

        tick(20);
        check_eq("R6 every expected write seen", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule